// File: doc/BRIEF.md
# Phase Build-Out Controller

This block lets a digital PLL change its reference without a phase step. When the active reference fails, the controller can hold the loop in a short holdover. During that holdover it measures how far the replacement reference sits from the present output phase. It adds that distance to a stored offset and subtracts the offset from every later phase-error sample. The loop therefore carries on from the phase it already had and does not slew to the new edge. The same sequence runs when the loop leaves a long holdover or free-run because a usable reference has come back. With build-out switched off, the loop receives the raw phase error and settles at zero phase to whichever reference it is given.

The controller is a five-state machine. The states are LOCKED, TEMP_HOLD, MEASURE, APPLY and HOLDOVER. The transitions are:

- T_FAIL_SWITCH: LOCKED to TEMP_HOLD when a reference fails, build-out is on and a candidate is valid.
- T_FAIL_NOREF: LOCKED to HOLDOVER when a reference fails with no valid candidate.
- T_RECOVER: HOLDOVER to TEMP_HOLD when a candidate becomes valid with build-out on.
- T_RECOVER_DIRECT: HOLDOVER to LOCKED when a candidate becomes valid with build-out off.
- T_ALIGNED: TEMP_HOLD to MEASURE on the switch-done strobe.
- T_RESTART: MEASURE to TEMP_HOLD, or to HOLDOVER, when a reference fails during measurement.
- T_AVERAGED: MEASURE to APPLY when the last averaging sample arrives.
- T_COMMIT: APPLY to LOCKED.

An align pulse on entry to MEASURE tells the input divider to snap its edge to the feedback edge, so the loop locks to the nearest edge.

Top module: `pbo_ctrl`

## Requirements
- R1: After reset the controller is in LOCKED. In that state the offset is zero, holdover and align are low, and the phase-error output equals the phase input.
- R2: While build-out is disabled and the controller is in LOCKED, the phase-error output equals the raw phase input. A reference failure that has a valid candidate leaves the controller in LOCKED with the offset unchanged.
- R3: With build-out enabled, a reference failure that has a valid candidate raises holdover from the next cycle. The phase-error output is zero in every cycle that holdover is high.
- R4: A reference failure with no valid candidate enters HOLDOVER and leaves the offset unchanged. In HOLDOVER, phase samples and switch-done are ignored. When a candidate becomes valid, the controller goes to TEMP_HOLD if build-out is enabled, or straight to LOCKED if it is disabled.
- R5: Switch-done in TEMP_HOLD starts measurement. The align output is high for exactly the first cycle of MEASURE.
- R6: Measurement takes 4 phase-strobe samples. On the edge after the fourth sample the controller enters APPLY. On the following edge the offset grows by the floor of the sample sum divided by 4 (arithmetic shift), and holdover falls.
- R7: In LOCKED with build-out enabled, the phase-error output is the phase input minus the offset, saturated to the signed 12-bit range [-2048, 2047].
- R8: The 14-bit signed offset saturates at 8191 and at -8192 instead of wrapping.
- R9: A reference failure during MEASURE discards the partial samples. Only the samples from the next complete measurement are added.
- R10: The offset-clear strobe sets the offset to zero on the next edge. It takes priority over an APPLY update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pbo_en | input | 1 | Build-out enable |
| ref_fail | input | 1 | Strobe: the active reference has failed |
| cand_valid | input | 1 | A valid replacement reference exists |
| switch_done | input | 1 | Strobe: the reference switch and edge alignment are done |
| ph_stb | input | 1 | Strobe: ph_diff holds a new per-cycle sample |
| ph_diff | input | 12 | Signed measured phase difference |
| offset_clr | input | 1 | Strobe: clear the stored offset |
| ph_err_out | output | 12 | Signed corrected phase error sent to the loop filter |
| holdover_o | output | 1 | The loop is in holdover (any state other than LOCKED) |
| align_o | output | 1 | One-cycle request to align the divided edge to the feedback edge |
| offset_o | output | 14 | Signed stored build-out offset |

## Verification
The assertions assume the three strobes are single-cycle pulses. They also assume that while reset is released, cand_valid and pbo_en change only between edges. The phase-error checks relate ph_err_out to ph_diff in the same cycle, so they rely on ph_diff being stable around the sampling edge. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It raises switch-done only after the controller has entered TEMP_HOLD, so the restart and ignore rules are exercised on purpose and never by an overlap of strobes.

// File: rtl/pbo_pkg.sv
package pbo_pkg;

    typedef enum logic [2:0] {
        PB_LOCKED    = 3'd0,
        PB_TEMP_HOLD = 3'd1,
        PB_MEASURE   = 3'd2,
        PB_APPLY     = 3'd3,
        PB_HOLDOVER  = 3'd4
    } pbo_state_e;

endpackage

// File: rtl/pbo_fsm.sv
module pbo_fsm
    import pbo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pbo_en,
    input  logic       ref_fail,
    input  logic       cand_valid,
    input  logic       switch_done,
    input  logic       meas_done,
    output pbo_state_e state_q,
    output logic       meas_start
);

    pbo_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PB_LOCKED: begin
                if (ref_fail) begin
                    if (!cand_valid)
                        state_d = PB_HOLDOVER;      // T_FAIL_NOREF
                    else if (pbo_en)
                        state_d = PB_TEMP_HOLD;     // T_FAIL_SWITCH
                end
            end
            PB_HOLDOVER: begin
                if (cand_valid)
                    state_d = pbo_en ? PB_TEMP_HOLD // T_RECOVER
                                     : PB_LOCKED;   // T_RECOVER_DIRECT
            end
            PB_TEMP_HOLD: begin
                if (ref_fail && !cand_valid)
                    state_d = PB_HOLDOVER;
                else if (!ref_fail && switch_done)
                    state_d = PB_MEASURE;           // T_ALIGNED
            end
            PB_MEASURE: begin
                if (ref_fail)
                    state_d = cand_valid ? PB_TEMP_HOLD : PB_HOLDOVER; // T_RESTART
                else if (meas_done)
                    state_d = PB_APPLY;             // T_AVERAGED
            end
            PB_APPLY: begin
                state_d = PB_LOCKED;                // T_COMMIT
            end
            default: state_d = PB_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PB_LOCKED;
        else
            state_q <= state_d;
    end

    assign meas_start = (state_q != PB_MEASURE) && (state_d == PB_MEASURE);

endmodule

// File: rtl/pbo_avg.sv
module pbo_avg #(
    parameter int PH_W      = 12,
    parameter int AVG_SHIFT = 2,
    localparam int SUM_W    = PH_W + AVG_SHIFT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    run,
    input  logic                    stb,
    input  logic signed [PH_W-1:0]  din,
    output logic                    done,
    output logic signed [SUM_W-1:0] avg
);

    localparam int CNT_W = (AVG_SHIFT > 0) ? AVG_SHIFT : 1;
    localparam int AVG_N = 1 << AVG_SHIFT;

    logic signed [SUM_W-1:0] sum_q;
    logic signed [SUM_W-1:0] din_x;
    logic        [CNT_W-1:0] cnt_q;

    generate
        if (AVG_SHIFT > 0) begin : g_ext
            assign din_x = {{AVG_SHIFT{din[PH_W-1]}}, din};
        end else begin : g_noext
            assign din_x = din;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (start) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (run && stb) begin
            sum_q <= sum_q + din_x;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && stb && (cnt_q == CNT_W'(AVG_N - 1));
    assign avg  = sum_q >>> AVG_SHIFT;

endmodule

// File: rtl/pbo_offset.sv
module pbo_offset #(
    parameter int OFS_W = 14,
    parameter int ADD_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    add_en,
    input  logic signed [ADD_W-1:0] addend,
    output logic signed [OFS_W-1:0] offset_q
);

    localparam int EXT = OFS_W + 1 - ADD_W;

    logic signed [OFS_W:0]   add_x;
    logic signed [OFS_W:0]   sum_x;
    logic signed [OFS_W-1:0] sat_v;

    assign add_x = {{EXT{addend[ADD_W-1]}}, addend};
    assign sum_x = {offset_q[OFS_W-1], offset_q} + add_x;

    always_comb begin
        if (sum_x[OFS_W] != sum_x[OFS_W-1])
            sat_v = sum_x[OFS_W] ? {1'b1, {(OFS_W-1){1'b0}}}
                                 : {1'b0, {(OFS_W-1){1'b1}}};
        else
            sat_v = sum_x[OFS_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            offset_q <= '0;
        else if (clr)
            offset_q <= '0;
        else if (add_en)
            offset_q <= sat_v;
    end

endmodule

// File: rtl/pbo_ctrl.sv
module pbo_ctrl
    import pbo_pkg::*;
#(
    parameter int PH_W      = 12,
    parameter int OFS_W     = 14,
    parameter int AVG_SHIFT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pbo_en,
    input  logic                    ref_fail,
    input  logic                    cand_valid,
    input  logic                    switch_done,
    input  logic                    ph_stb,
    input  logic signed [PH_W-1:0]  ph_diff,
    input  logic                    offset_clr,
    output logic signed [PH_W-1:0]  ph_err_out,
    output logic                    holdover_o,
    output logic                    align_o,
    output logic signed [OFS_W-1:0] offset_o
);

    localparam int SUM_W = PH_W + AVG_SHIFT;
    localparam int PEXT  = OFS_W + 1 - PH_W;

    pbo_state_e              state_q;
    logic                    meas_start;
    logic                    meas_done;
    logic signed [SUM_W-1:0] avg_v;
    logic signed [OFS_W:0]   diff_x;
    logic signed [PH_W-1:0]  corr_v;
    logic                    fits;
    logic                    align_q;

    pbo_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pbo_en     (pbo_en),
        .ref_fail   (ref_fail),
        .cand_valid (cand_valid),
        .switch_done(switch_done),
        .meas_done  (meas_done),
        .state_q    (state_q),
        .meas_start (meas_start)
    );

    pbo_avg #(.PH_W(PH_W), .AVG_SHIFT(AVG_SHIFT)) u_avg (
        .clk  (clk),
        .rst_n(rst_n),
        .start(meas_start),
        .run  (state_q == PB_MEASURE),
        .stb  (ph_stb),
        .din  (ph_diff),
        .done (meas_done),
        .avg  (avg_v)
    );

    pbo_offset #(.OFS_W(OFS_W), .ADD_W(SUM_W)) u_ofs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (offset_clr),
        .add_en  (state_q == PB_APPLY),
        .addend  (avg_v),
        .offset_q(offset_o)
    );

    // corrected error: raw phase minus offset, clipped to the phase range
    assign diff_x = {{PEXT{ph_diff[PH_W-1]}}, ph_diff} - {offset_o[OFS_W-1], offset_o};
    assign fits   = (diff_x[OFS_W:PH_W-1] == '0) || (diff_x[OFS_W:PH_W-1] == '1);

    always_comb begin
        if (fits)
            corr_v = diff_x[PH_W-1:0];
        else
            corr_v = diff_x[OFS_W] ? {1'b1, {(PH_W-1){1'b0}}}
                                   : {1'b0, {(PH_W-1){1'b1}}};
    end

    always_comb begin
        unique case (state_q)
            PB_LOCKED: begin
                holdover_o = 1'b0;
                ph_err_out = pbo_en ? corr_v : ph_diff;
            end
            PB_TEMP_HOLD, PB_MEASURE, PB_APPLY, PB_HOLDOVER: begin
                holdover_o = 1'b1;
                ph_err_out = '0;
            end
            default: begin
                holdover_o = 1'b1;
                ph_err_out = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            align_q <= 1'b0;
        else
            align_q <= meas_start;
    end

    assign align_o = align_q;

endmodule

// File: rtl/pbo_ctrl_chk.sv
module pbo_ctrl_chk #(
    parameter int PH_W  = 12,
    parameter int OFS_W = 14
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    pbo_en,
    input logic                    ref_fail,
    input logic                    cand_valid,
    input logic signed [PH_W-1:0]  ph_diff,
    input logic                    offset_clr,
    input logic signed [PH_W-1:0]  ph_err_out,
    input logic                    holdover_o,
    input logic                    align_o,
    input logic signed [OFS_W-1:0] offset_o
);

    // R3
    hold_mutes_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        holdover_o |-> ph_err_out == '0);

    // R3
    fail_enters_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pbo_en && ref_fail && cand_valid && !holdover_o) |=> holdover_o);

    // R5
    align_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_o |=> !align_o);

    // R5
    align_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_o |-> holdover_o);

    // R6
    offset_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!offset_clr && !holdover_o) |=> $stable(offset_o));

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offset_clr |=> offset_o == '0);

    // R2
    bypass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pbo_en && !holdover_o) |-> ph_err_out == ph_diff);

endmodule

bind pbo_ctrl pbo_ctrl_chk #(.PH_W(PH_W), .OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pbo_en    (pbo_en),
    .ref_fail  (ref_fail),
    .cand_valid(cand_valid),
    .ph_diff   (ph_diff),
    .offset_clr(offset_clr),
    .ph_err_out(ph_err_out),
    .holdover_o(holdover_o),
    .align_o   (align_o),
    .offset_o  (offset_o)
);

// File: tb/pbo_ctrl_tb.sv
`timescale 1ns/1ps
module pbo_ctrl_tb_top;

    localparam int PH_W  = 12;
    localparam int OFS_W = 14;

    // per vector: four samples, resulting offset, probe phase, expected error
    localparam int VS [4][4] = '{'{100, 100, 100, 100},
                                 '{-10, -11, -12, -13},
                                 '{1, 2, 3, 1},
                                 '{2000, 2000, 2000, 2000}};
    localparam int VOFF [4]   = '{100, 88, 89, 2089};
    localparam int VPROBE [4] = '{150, 0, -2048, 2047};
    localparam int VERR [4]   = '{50, -88, -2048, -42};

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    pbo_en = 1'b1;
    logic                    ref_fail = 1'b0;
    logic                    cand_valid = 1'b1;
    logic                    switch_done = 1'b0;
    logic                    ph_stb = 1'b0;
    logic signed [PH_W-1:0]  ph_diff = '0;
    logic                    offset_clr = 1'b0;
    logic signed [PH_W-1:0]  ph_err_out;
    logic                    holdover_o;
    logic                    align_o;
    logic signed [OFS_W-1:0] offset_o;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pbo_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pbo_en(pbo_en), .ref_fail(ref_fail),
        .cand_valid(cand_valid), .switch_done(switch_done), .ph_stb(ph_stb),
        .ph_diff(ph_diff), .offset_clr(offset_clr), .ph_err_out(ph_err_out),
        .holdover_o(holdover_o), .align_o(align_o), .offset_o(offset_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_fail();
        ref_fail = 1'b1;
        @(negedge clk);
        ref_fail = 1'b0;
    endtask

    task automatic do_measure(input int s0, input int s1, input int s2, input int s3,
                              input bit clr_at_apply);
        int smp [4];
        smp = '{s0, s1, s2, s3};
        switch_done = 1'b1;
        @(negedge clk);
        switch_done = 1'b0;
        chk("R5 align high", int'(align_o), 1);
        @(negedge clk);
        chk("R5 align single", int'(align_o), 0);
        for (int k = 0; k < 4; k++) begin
            ph_stb = 1'b1;
            ph_diff = smp[k][PH_W-1:0];
            @(negedge clk);
        end
        ph_stb = 1'b0;
        ph_diff = '0;
        chk("R6 apply still hold", int'(holdover_o), 1);
        offset_clr = clr_at_apply;
        @(negedge clk);
        offset_clr = 1'b0;
        chk("R6 hold released", int'(holdover_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ph_diff = 12'sd321;
        @(negedge clk);
        // R1 reset state
        chk("R1 offset", int'(offset_o), 0);
        chk("R1 holdover", int'(holdover_o), 0);
        chk("R1 align", int'(align_o), 0);
        chk("R1 err", int'(ph_err_out), 321);

        // R6 R7 table of build-out sequences
        for (int v = 0; v < 4; v++) begin
            do_fail();
            chk("R3 hold", int'(holdover_o), 1);
            chk("R3 err zero", int'(ph_err_out), 0);
            do_measure(VS[v][0], VS[v][1], VS[v][2], VS[v][3], 1'b0);
            chk("R6 offset", int'(offset_o), VOFF[v]);
            ph_diff = VPROBE[v][PH_W-1:0];
            #1;
            chk("R7 corrected err", int'(ph_err_out), VERR[v]);
        end

        // R2 bypass
        pbo_en = 1'b0;
        ph_diff = 12'sd300;
        #1;
        chk("R2 raw err", int'(ph_err_out), 300);
        do_fail();
        chk("R2 stays locked", int'(holdover_o), 0);
        chk("R2 offset kept", int'(offset_o), 2089);

        // R4 disabled: holdover then direct relock
        cand_valid = 1'b0;
        do_fail();
        chk("R4 hold", int'(holdover_o), 1);
        cand_valid = 1'b1;
        @(negedge clk);
        chk("R4 direct relock", int'(holdover_o), 0);
        pbo_en = 1'b1;

        // R4 enabled: no candidate, strobes ignored
        cand_valid = 1'b0;
        do_fail();
        chk("R4 hold noref", int'(holdover_o), 1);
        switch_done = 1'b1;
        ph_stb = 1'b1;
        ph_diff = 12'sd500;
        repeat (3) @(negedge clk);
        switch_done = 1'b0;
        ph_stb = 1'b0;
        chk("R4 still hold", int'(holdover_o), 1);
        chk("R4 no align", int'(align_o), 0);
        chk("R4 offset kept", int'(offset_o), 2089);
        cand_valid = 1'b1;
        @(negedge clk);
        chk("R4 recover hold", int'(holdover_o), 1);
        do_measure(8, 8, 8, 8, 1'b0);
        chk("R4 recover offset", int'(offset_o), 2097);

        // R9 restart mid measurement
        do_fail();
        switch_done = 1'b1;
        @(negedge clk);
        switch_done = 1'b0;
        ph_stb = 1'b1;
        ph_diff = 12'sd1000;
        repeat (2) @(negedge clk);
        ph_stb = 1'b0;
        do_fail();
        chk("R9 hold after restart", int'(holdover_o), 1);
        do_measure(40, 40, 40, 40, 1'b0);
        chk("R9 offset", int'(offset_o), 2137);

        // R10 clear in locked and against apply
        offset_clr = 1'b1;
        @(negedge clk);
        offset_clr = 1'b0;
        chk("R10 clear", int'(offset_o), 0);
        do_fail();
        do_measure(77, 77, 77, 77, 1'b1);
        chk("R10 clear beats apply", int'(offset_o), 0);

        // R8 positive saturation
        for (int n = 0; n < 5; n++) begin
            do_fail();
            do_measure(2047, 2047, 2047, 2047, 1'b0);
            chk("R8 pos accum", int'(offset_o), (n < 4) ? 2047 * (n + 1) : 8191);
        end
        offset_clr = 1'b1;
        @(negedge clk);
        offset_clr = 1'b0;
        // R8 negative saturation
        for (int n = 0; n < 5; n++) begin
            do_fail();
            do_measure(-2048, -2048, -2048, -2048, 1'b0);
            chk("R8 neg accum", int'(offset_o), (n < 4) ? -2048 * (n + 1) : -8192);
        end
        ph_diff = 12'sd2047;
        #1;
        chk("R7 err clip high", int'(ph_err_out), 2047);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule